// File: doc/BRIEF.md
# Receive descriptor ring engine

This block moves received serial bytes into memory buffers that software hands over through a ring of descriptors. Each descriptor lives in a shared word memory. It holds four 16-bit words: a status word at offset 0, a byte count at offset 2, and a 32-bit buffer pointer whose high half is at offset 4 and low half at offset 6. The host owns a descriptor while its empty flag is clear. The engine may only fill a descriptor whose empty flag the host has set.

The engine fetches the current descriptor and fills its buffer one byte at a time. It closes the buffer when one of six things happens: a control character, a receive error, carrier loss, the buffer reaching its programmed size, a hunt command, or a close command. On closing it writes back the count and then the status, and moves on to the next descriptor. A wrap flag in a descriptor sends the engine back to the ring base.

If the next descriptor is still owned by the host, incoming bytes are dropped and a busy event is raised. The engine keeps polling that descriptor until the host returns it.

The shared memory answers a read in the cycle after the request and takes a write in the cycle it is requested. Bytes arrive at least 8 cycles apart. The buffer size input is held constant while a buffer is open.

Top module: `rx_desc_ring`

## Requirements
- R1: While reset is active or `enable` is low, the engine makes no memory request and both event outputs stay low. After `enable` rises, its first memory access is a read of the status word at `ringBase`.
- R2: A descriptor is fetched as three reads in this order: status (+0), pointer high (+4), pointer low (+6). The pointer reads happen only when status bit 15 (empty) reads as 1.
- R3: Byte n of a buffer is written to byte address pointer+n. An even address uses data bits 15:8 with `memBe`=2'b10. An odd address uses bits 7:0 with `memBe`=2'b01.
- R4: When the byte count reaches `maxLen`, the buffer closes with status bit 4 (full) set, and the length word equals `maxLen`.
- R5: A byte flagged by `rxCtl` is stored and then closes the buffer with status bit 7 set. Bit 4 is also set if that byte filled the buffer.
- R6: `rxErr` closes the open buffer with bits 1 and 11 (last) set. `rxCdLost` closes it with bits 0 and 11 set. The length word holds the bytes stored so far.
- R7: `cmdHunt` closes the open buffer with bits 3 and 11 set. `cmdClose` closes it with bit 3 only. Close events arriving while no buffer is open are ignored. If an event and a waiting byte meet, the event wins and the byte goes to the next buffer.
- R8: A close writes the length word (+2) and then the status word (+0), with no write in between. The status word is the last write of the close. In it, bit 15 is 0, bits 13 (wrap) and 12 (interrupt) are copied from the fetched status, the close-cause bits are set, and every other bit is 0, including bits 14, 8, 6 and 5.
- R9: After a close, the next status read is at the closed descriptor + 8. If the closed descriptor had bit 13 set, the next read is at `ringBase` instead.
- R10: `evRx` pulses for exactly one cycle, in the cycle after the status write of a closed descriptor, if and only if that descriptor's bit 12 was set.
- R11: While the current descriptor has bit 15 clear, an arriving byte is discarded without any memory write, and `evBusy` pulses once. The descriptor keeps being re-read, and reception resumes once the host sets its bit 15.
- R12: Close-cause bits and the byte count start from zero for every newly opened buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine run; low returns to idle and reloads the ring base |
| ringBase | input | AW | Byte address of the first descriptor |
| maxLen | input | LW | Buffer size in bytes |
| rxValid | input | 1 | A received byte is presented |
| rxByte | input | 8 | Received byte |
| rxCtl | input | 1 | The presented byte is a control character |
| rxErr | input | 1 | Receive error pulse |
| rxCdLost | input | 1 | Carrier lost pulse |
| cmdHunt | input | 1 | Host hunt command pulse |
| cmdClose | input | 1 | Host close-buffer command pulse |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | AW | Byte address (even for word accesses) |
| memWdata | output | 16 | Write data |
| memBe | output | 2 | Byte lane enables, bit 1 = bits 15:8 |
| memRdata | input | 16 | Read data, valid the cycle after a read request |
| evRx | output | 1 | Buffer-closed event pulse |
| evBusy | output | 1 | Byte-dropped event pulse |

## Verification
A wrong internal state shows up in memory. A stale byte count gives a wrong length word, or a byte at the wrong address, as soon as the next close occurs. Flags that are not cleared on opening show up as extra status bits in the next closed descriptor. A wrong ring pointer shows up as an unexpected status read address right after the status write, or as an engine that never leaves a blocked descriptor the host has returned. A lost ownership check shows up as buffer writes in the cycles after a byte arrives while the descriptor is still owned by the host.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_RD_STAT, OP_RD_PHI, OP_RD_PLO, OP_WR_BYTE, OP_WR_LEN, OP_WR_STAT
  } memOp_e;

  typedef enum logic [2:0] {
    CZ_NONE, CZ_HUNT, CZ_CMD, CZ_ERR, CZ_CDL
  } closeCause_e;

  typedef struct packed {
    memOp_e      op;
    logic        capStat;
    logic        capPhi;
    logic        capPlo;
    logic        openBuf;
    logic        byteDone;
    logic        dropByte;
    closeCause_e cause;
    logic        advance;
  } dpStrobe_t;

  localparam int EMPTY_B = 15;
  localparam int WRAP_B  = 13;
  localparam int INTR_B  = 12;
  localparam int LAST_B  = 11;
  localparam int CTRL_B  = 7;
  localparam int FULL_B  = 4;
  localparam int HOST_B  = 3;
  localparam int ERR_B   = 1;
  localparam int CDL_B   = 0;
  localparam logic [15:0] RSV_MASK = 16'h4160;
endpackage

// File: rtl/rxr_dpath.sv
module rxr_dpath
  import rxr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [AW-1:0] ringBase,
  input  logic [LW-1:0] maxLen,
  input  logic          rxValid,
  input  logic [7:0]    rxByte,
  input  logic          rxCtl,
  input  dpStrobe_t     s,
  input  logic [15:0]   memRdata,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [15:0]   memWdata,
  output logic [1:0]    memBe,
  output logic          pendValid,
  output logic          pendCtl,
  output logic          hitMax,
  output logic          rdEmpty,
  output logic          intrFlag
);
  localparam int DESC_BYTES = 8;

  logic [AW-1:0] descAddr;
  logic          wrapF, intrF, lastF, ctrlF, fullF, hostF, errF, cdlF;
  logic [15:0]   ptrHi, ptrLo;
  logic [31:0]   ptrFull;
  logic [LW-1:0] count;
  logic [LW:0]   nextCount;
  logic [AW-1:0] byteAddr;
  logic [7:0]    pendByte;
  logic [15:0]   statWord;

  assign ptrFull   = {ptrHi, ptrLo};
  assign byteAddr  = ptrFull[AW-1:0] + AW'(count);
  assign nextCount = {1'b0, count} + 1'b1;
  assign hitMax    = nextCount >= {1'b0, maxLen};
  assign rdEmpty   = memRdata[EMPTY_B];
  assign intrFlag  = intrF;

  always_comb begin
    statWord         = '0;
    statWord[WRAP_B] = wrapF;
    statWord[INTR_B] = intrF;
    statWord[LAST_B] = lastF;
    statWord[CTRL_B] = ctrlF;
    statWord[FULL_B] = fullF;
    statWord[HOST_B] = hostF;
    statWord[ERR_B]  = errF;
    statWord[CDL_B]  = cdlF;
  end

  always_comb begin
    memReq   = 1'b1;
    memWe    = 1'b0;
    memAddr  = descAddr;
    memWdata = '0;
    memBe    = 2'b11;
    case (s.op)
      OP_RD_STAT: memAddr = descAddr;
      OP_RD_PHI:  memAddr = descAddr + AW'(4);
      OP_RD_PLO:  memAddr = descAddr + AW'(6);
      OP_WR_BYTE: begin
        memWe    = 1'b1;
        memAddr  = byteAddr;
        memWdata = {pendByte, pendByte};
        memBe    = byteAddr[0] ? 2'b01 : 2'b10;
      end
      OP_WR_LEN: begin
        memWe    = 1'b1;
        memAddr  = descAddr + AW'(2);
        memWdata = 16'(count);
      end
      OP_WR_STAT: begin
        memWe    = 1'b1;
        memWdata = statWord;
      end
      default: memReq = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr <= '0;
      {wrapF, intrF, lastF, ctrlF, fullF, hostF, errF, cdlF} <= '0;
      ptrHi <= '0;
      ptrLo <= '0;
      count <= '0;
      pendValid <= 1'b0;
      pendByte <= '0;
      pendCtl <= 1'b0;
    end else begin
      if (!enable)       descAddr <= ringBase;
      else if (s.advance) descAddr <= wrapF ? ringBase : descAddr + AW'(DESC_BYTES);

      if (s.capStat) begin
        wrapF <= memRdata[WRAP_B];
        intrF <= memRdata[INTR_B];
      end
      if (s.capPhi) ptrHi <= memRdata;
      if (s.capPlo) ptrLo <= memRdata;

      if (s.openBuf) begin
        count <= '0;
        {lastF, ctrlF, fullF, hostF, errF, cdlF} <= '0;
      end else if (s.byteDone) begin
        count <= nextCount[LW-1:0];
        if (pendCtl) ctrlF <= 1'b1;
        if (hitMax)  fullF <= 1'b1;
      end else begin
        case (s.cause)
          CZ_HUNT: begin hostF <= 1'b1; lastF <= 1'b1; end
          CZ_CMD:  hostF <= 1'b1;
          CZ_ERR:  begin errF <= 1'b1; lastF <= 1'b1; end
          CZ_CDL:  begin cdlF <= 1'b1; lastF <= 1'b1; end
          default: ;
        endcase
      end

      if (!enable) pendValid <= 1'b0;
      else if (rxValid) begin
        pendValid <= 1'b1;
        pendByte  <= rxByte;
        pendCtl   <= rxCtl;
      end else if (s.byteDone || s.dropByte) pendValid <= 1'b0;
    end
  end

  // R8
  stat_format_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && s.op == OP_WR_STAT) |-> ((memWdata & RSV_MASK) == 16'h0 && !memWdata[EMPTY_B]));

  // R11
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && s.dropByte && !rxValid) |=> !pendValid);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s.byteDone && $stable(maxLen) && maxLen != '0) |-> (count < maxLen));
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      pendValid,
  input  logic      pendCtl,
  input  logic      hitMax,
  input  logic      rdEmpty,
  input  logic      intrFlag,
  input  logic      cmdHunt,
  input  logic      cmdClose,
  input  logic      rxErr,
  input  logic      rxCdLost,
  output dpStrobe_t s,
  output logic      evRx,
  output logic      evBusy
);
  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_CST, S_CPH, S_CPL, S_OPEN, S_WLEN, S_WST
  } state_e;

  state_e st, nxt;
  logic   blocked;

  always_comb begin
    s   = '0;
    nxt = st;
    case (st)
      S_IDLE: nxt = S_RST;
      S_RST: begin
        s.op = OP_RD_STAT;
        nxt  = S_CST;
      end
      S_CST: begin
        if (rdEmpty) begin
          s.capStat = 1'b1;
          s.op      = OP_RD_PHI;
          nxt       = S_CPH;
        end else nxt = S_RST;
      end
      S_CPH: begin
        s.capPhi = 1'b1;
        s.op     = OP_RD_PLO;
        nxt      = S_CPL;
      end
      S_CPL: begin
        s.capPlo  = 1'b1;
        s.openBuf = 1'b1;
        nxt       = S_OPEN;
      end
      S_OPEN: begin
        if (cmdHunt)       begin s.cause = CZ_HUNT; nxt = S_WLEN; end
        else if (cmdClose) begin s.cause = CZ_CMD;  nxt = S_WLEN; end
        else if (rxErr)    begin s.cause = CZ_ERR;  nxt = S_WLEN; end
        else if (rxCdLost) begin s.cause = CZ_CDL;  nxt = S_WLEN; end
        else if (pendValid) begin
          s.op       = OP_WR_BYTE;
          s.byteDone = 1'b1;
          if (pendCtl || hitMax) nxt = S_WLEN;
        end
      end
      S_WLEN: begin
        s.op = OP_WR_LEN;
        nxt  = S_WST;
      end
      S_WST: begin
        s.op      = OP_WR_STAT;
        s.advance = 1'b1;
        nxt       = S_RST;
      end
      default: nxt = S_IDLE;
    endcase
    s.dropByte = blocked && pendValid && (st == S_RST || st == S_CST);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      st      <= S_IDLE;
      blocked <= 1'b0;
      evRx    <= 1'b0;
      evBusy  <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_CST) blocked <= !rdEmpty;
      evRx   <= (st == S_WST) && intrFlag;
      evBusy <= s.dropByte;
    end
  end

  // R8
  len_then_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (s.op == OP_WR_STAT) |-> ($past(s.op) == OP_WR_LEN));

  // R10
  irq_after_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    evRx |-> ($past(s.op) == OP_WR_STAT));

  // R11
  no_fill_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    blocked |-> (s.op != OP_WR_BYTE));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!evRx && !evBusy && s.op == OP_NONE));
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [AW-1:0] ringBase,
  input  logic [LW-1:0] maxLen,
  input  logic          rxValid,
  input  logic [7:0]    rxByte,
  input  logic          rxCtl,
  input  logic          rxErr,
  input  logic          rxCdLost,
  input  logic          cmdHunt,
  input  logic          cmdClose,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [15:0]   memWdata,
  output logic [1:0]    memBe,
  input  logic [15:0]   memRdata,
  output logic          evRx,
  output logic          evBusy
);
  dpStrobe_t strb;
  logic pendValid, pendCtl, hitMax, rdEmpty, intrFlag;

  rxr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .pendValid(pendValid), .pendCtl(pendCtl), .hitMax(hitMax),
    .rdEmpty(rdEmpty), .intrFlag(intrFlag),
    .cmdHunt(cmdHunt), .cmdClose(cmdClose), .rxErr(rxErr), .rxCdLost(rxCdLost),
    .s(strb), .evRx(evRx), .evBusy(evBusy)
  );

  rxr_dpath #(.AW(AW), .LW(LW)) i_dpath (
    .clk(clk), .rstN(rstN), .enable(enable),
    .ringBase(ringBase), .maxLen(maxLen),
    .rxValid(rxValid), .rxByte(rxByte), .rxCtl(rxCtl),
    .s(strb), .memRdata(memRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe),
    .pendValid(pendValid), .pendCtl(pendCtl), .hitMax(hitMax),
    .rdEmpty(rdEmpty), .intrFlag(intrFlag)
  );
endmodule

// File: tb/test_rx_desc_ring.sv
module test_rx_desc_ring;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rstN, enable;
  logic [31:0] ringBase;
  logic [15:0] maxLen;
  logic rxValid, rxCtl, rxErr, rxCdLost, cmdHunt, cmdClose;
  logic [7:0] rxByte;
  logic memReq, memWe, evRx, evBusy;
  logic [31:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic [1:0] memBe;

  logic hostWe = 1'b0;
  logic [31:0] hostAddr = '0;
  logic [15:0] hostData = '0;

  bit [15:0] mem [0:2047];
  int checks = 0, fails = 0;
  int dutWrites = 0, rxEvents = 0, busyEvents = 0, orderBad = 0;
  int rdCnt = 0;
  logic [31:0] rdLog [0:2];
  logic [31:0] lastWr = '0, nextRd = '0;
  logic waitNext = 1'b0;
  logic intrArr [0:3];
  logic [7:0] expBytes [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_ring i_rx_desc_ring (
    .clk(clk), .rstN(rstN), .enable(enable), .ringBase(ringBase), .maxLen(maxLen),
    .rxValid(rxValid), .rxByte(rxByte), .rxCtl(rxCtl), .rxErr(rxErr), .rxCdLost(rxCdLost),
    .cmdHunt(cmdHunt), .cmdClose(cmdClose),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .memRdata(memRdata), .evRx(evRx), .evBusy(evBusy)
  );

  // memory model and port monitor
  always @(posedge clk) begin
    if (hostWe) mem[hostAddr[11:1]] <= hostData;
    if (memReq && memWe) begin
      if (memBe[1]) mem[memAddr[11:1]][15:8] <= memWdata[15:8];
      if (memBe[0]) mem[memAddr[11:1]][7:0]  <= memWdata[7:0];
      dutWrites <= dutWrites + 1;
      lastWr <= memAddr;
      if (memAddr >= BASE && memAddr < BASE + 32 && memAddr[2:0] == 3'd0) begin
        if (lastWr != memAddr + 2) orderBad <= orderBad + 1;
        waitNext <= 1'b1;
      end
    end
    if (memReq && !memWe) begin
      memRdata <= mem[memAddr[11:1]];
      if (rdCnt < 3) rdLog[rdCnt] <= memAddr;
      rdCnt <= rdCnt + 1;
      if (waitNext) begin nextRd <= memAddr; waitNext <= 1'b0; end
    end
    if (evRx)   rxEvents <= rxEvents + 1;
    if (evBusy) busyEvents <= busyEvents + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [7:0] rdByte(input logic [31:0] a);
    return a[0] ? mem[a[11:1]][7:0] : mem[a[11:1]][15:8];
  endfunction

  function automatic logic [31:0] ptrOf(input int i);
    return 32'h400 + 32'(i * 32) + 32'(i & 1);
  endfunction

  function automatic string reqOf(input int scen);
    case (scen)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [15:0] expStat(input int scen, input logic w, input logic irq, input bit full);
    logic [15:0] v;
    v = 16'h0;
    v[13] = w;
    v[12] = irq;
    case (scen)
      0: v[4] = 1'b1;
      1: begin v[7] = 1'b1; v[4] = full; end
      2: begin v[1] = 1'b1; v[11] = 1'b1; end
      3: begin v[0] = 1'b1; v[11] = 1'b1; end
      4: begin v[3] = 1'b1; v[11] = 1'b1; end
      default: v[3] = 1'b1;
    endcase
    return v;
  endfunction

  task automatic hostWr(input logic [31:0] a, input logic [15:0] d);
    hostAddr = a; hostData = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic initRing(input int n);
    for (int i = 3; i >= 0; i--) begin
      logic [31:0] d;
      logic [15:0] st;
      d = BASE + 32'(i * 8);
      for (int w = 0; w < 16; w++) hostWr(32'h400 + 32'(i * 32) + 32'(w * 2), 16'h0);
      intrArr[i] = (i % 2 == 0) ? 1'b1 : 1'($urandom_range(0, 1));
      hostWr(d + 2, 16'h0);
      hostWr(d + 4, ptrOf(i)[31:16]);
      hostWr(d + 6, ptrOf(i)[15:0]);
      st = 16'h0;
      if (i < n) begin
        st[15] = 1'b1;
        st[13] = (i == n - 1);
        st[12] = intrArr[i];
      end
      hostWr(d, st);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic c);
    rxByte = b; rxCtl = c; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0; rxCtl = 1'b0;
    repeat (9) @(negedge clk);
  endtask

  task automatic runDesc(input int i, input int n, input int g);
    int scen, k, r0;
    bit full;
    logic [31:0] d, expNext, badAct, badExp;
    bit bytesOk;
    scen = (g < 6) ? g : int'($urandom_range(0, 5));
    if (scen == 0)      k = maxLen;
    else if (scen == 1) k = int'($urandom_range(1, maxLen));
    else                k = int'($urandom_range(0, maxLen - 1));
    full = (k == int'(maxLen));
    r0 = rxEvents;
    for (int j = 0; j < k; j++) begin
      expBytes[j] = 8'($urandom);
      sendByte(expBytes[j], (scen == 1 && j == k - 1));
    end
    case (scen)
      2: rxErr = 1'b1;
      3: rxCdLost = 1'b1;
      4: cmdHunt = 1'b1;
      5: cmdClose = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    {rxErr, rxCdLost, cmdHunt, cmdClose} = '0;
    repeat (14) @(negedge clk);
    d = BASE + 32'(i * 8);
    // R8 R12: exact status word, flags from earlier buffers must not leak in
    chk(mem[d[11:1]] == expStat(scen, (i == n - 1), intrArr[i], full),
        reqOf(scen), "R8 R12 status", mem[d[11:1]], expStat(scen, (i == n - 1), intrArr[i], full));
    chk(mem[d[11:1] + 1] == 16'(k), reqOf(scen), "length", mem[d[11:1] + 1], k);
    bytesOk = 1'b1; badAct = '0; badExp = '0;
    for (int j = 0; j < k; j++)
      if (bytesOk && rdByte(ptrOf(i) + 32'(j)) != expBytes[j]) begin
        bytesOk = 1'b0; badAct = 32'(rdByte(ptrOf(i) + 32'(j))); badExp = 32'(expBytes[j]);
      end
    chk(bytesOk, "R3", "buffer bytes", badAct, badExp);
    chk((rxEvents - r0) == int'(intrArr[i]), "R10", "evRx pulses", rxEvents - r0, intrArr[i]);
    expNext = (i == n - 1) ? BASE : d + 8;
    chk(nextRd == expNext, "R9", "next descriptor read", nextRd, expNext);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    int g, wb, bb;
    void'($urandom(32'd2024));
    rstN = 1'b0; enable = 1'b0; ringBase = BASE; maxLen = 16'd8;
    rxValid = 1'b0; rxByte = '0; rxCtl = 1'b0; rxErr = 1'b0; rxCdLost = 1'b0;
    cmdHunt = 1'b0; cmdClose = 1'b0;
    repeat (4) @(negedge clk);
    chk(!memReq && !evRx && !evBusy, "R1", "outputs in reset", {memReq, evRx, evBusy}, 0);
    rstN = 1'b1;
    initRing(4);
    chk(!memReq && !evRx && !evBusy && rdCnt == 0, "R1", "idle while disabled", rdCnt, 0);
    enable = 1'b1;
    repeat (12) @(negedge clk);
    chk(rdLog[0] == BASE, "R1", "first read at ring base", rdLog[0], BASE);
    chk(rdLog[1] == BASE + 4 && rdLog[2] == BASE + 6, "R2", "pointer read order",
        {rdLog[1], rdLog[2]}, {BASE + 4, BASE + 6});
    g = 0;
    for (int lap = 0; lap < 3; lap++) begin
      int n;
      n = (lap == 1) ? 3 : 4;
      if (lap > 0) begin
        maxLen = 16'($urandom_range(3, 12));
        initRing(n);
        repeat (14) @(negedge clk);
      end
      for (int i = 0; i < n; i++) begin
        runDesc(i, n, g);
        g++;
      end
      // descriptor 0 is now host-owned: a byte must be dropped (R11)
      wb = dutWrites; bb = busyEvents;
      sendByte(8'hA5, 1'b0);
      repeat (4) @(negedge clk);
      chk((busyEvents - bb) == 1, "R11", "busy pulse on owned descriptor", busyEvents - bb, 1);
      chk(dutWrites == wb, "R11", "no write while blocked", dutWrites - wb, 0);
    end
    chk(orderBad == 0, "R8", "length written just before status", orderBad, 0);
    finishRun();
  end
endmodule